// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor

This unit adds or subtracts two N-bit signed numbers in sign-magnitude form. The top bit of each word is the sign and the lower N-1 bits are an unsigned magnitude. A single select bit picks addition or subtraction.

The unit does not use a two's complement adder. It first works out the effective sign of the second operand. It then compares the two signs. If the signs match, the magnitudes are added. If they differ, a single magnitude subtraction runs, and its borrow decides both the result sign and which difference to pass on. Any result whose magnitude is zero is reported as positive zero. An overflow flag marks a magnitude sum that no longer fits in N-1 bits.

The result can be taken straight from the logic, or through one optional register stage that clears on reset.

Top module: `sm_addsub`

## Requirements
- R1: Operand and result encoding: bit N-1 is the sign (0 positive, 1 negative) and bits N-2..0 are the unsigned magnitude. `op_sel` = 0 selects addition. Both encodings of zero are accepted as inputs.
- R2: `op_sel` = 1 selects subtraction. It behaves exactly like addition with the sign bit of `op_b` inverted.
- R3: When the sign of `op_a` equals the effective sign of `op_b` and the sum fits, the result magnitude is the sum of the magnitudes and the result sign is the sign of `op_a`.
- R4: When the signs differ and the magnitude of `op_a` is larger, the result is (magnitude of `op_a` minus magnitude of `op_b`) with the sign of `op_a`.
- R5: When the signs differ and the magnitude of `op_b` is larger, the result is (magnitude of `op_b` minus magnitude of `op_a`) with the effective sign of `op_b`.
- R6: When the signs differ and the magnitudes are equal, the result is positive zero (all bits 0) and the overflow flag is 0.
- R7: Adding two zeros of the same effective sign gives positive zero. This includes negative zero plus negative zero. No result with zero magnitude ever carries sign 1.
- R8: `ovf` is 1 exactly when the magnitude sum carries out of N-1 bits, which can only happen when the signs match. The result magnitude is then the low N-1 bits of the sum. Its sign is the sign of `op_a`, unless those bits are zero, in which case the sign is 0.
- R9: With `REG_OUT` = 1, `res` and `ovf` appear one clock after the operands are presented. An active-low `rst_n` clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | N | First operand, sign-magnitude |
| op_b | input | N | Second operand, sign-magnitude |
| op_sel | input | 1 | 0 = add, 1 = subtract |
| res | output | N | Result, sign-magnitude |
| ovf | output | 1 | Magnitude overflow flag |

## Verification
Two rules can apply in the same cycle: overflow truncation and the rule that forces a zero magnitude to a positive sign. The sharpest case is two operands of magnitude 2^(N-2) with a common effective sign, for example -8 plus -8 at N=5. Here the truncated magnitude is zero and the flag is raised at the same time. Subtraction can also turn opposite stored signs into a matching effective sign, so that overflow comes from a subtract.

The sweep covers every operand pair under both operations at N=5. For each pair it compares `res` and `ovf` with an integer model that computes the true sum or difference, reduces it to magnitude and sign, and applies truncation and the positive-zero rule.

// File: rtl/sm_pkg.sv
package sm_pkg;

    typedef enum logic {
        SMOP_ADD = 1'b0,
        SMOP_SUB = 1'b1
    } sm_op_e;

endpackage

// File: rtl/sm_mag_add.sv
module sm_mag_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         carry
);
    logic [W:0] wide;

    always_comb begin
        wide  = {1'b0, x} + {1'b0, y};
        sum   = wide[W-1:0];
        carry = wide[W];
    end
endmodule

// File: rtl/sm_mag_cmp.sv
module sm_mag_cmp #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] d_xy,
    output logic [W-1:0] d_yx,
    output logic         x_lt_y
);
    logic [W:0] wide;

    always_comb begin
        wide   = {1'b0, x} - {1'b0, y};
        x_lt_y = wide[W];
        d_xy   = wide[W-1:0];
        d_yx   = (~wide[W-1:0]) + W'(1);
    end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         op_sel,
    output logic [N-1:0] res,
    output logic         ovf
);
    import sm_pkg::*;

    localparam int W = N - 1;

    typedef struct packed {
        logic         sign;
        logic [W-1:0] mag;
        logic         ovf;
    } sm_out_t;

    logic         sgn_a;
    logic         sgn_b_eff;
    logic [W-1:0] mag_a;
    logic [W-1:0] mag_b;
    logic [W-1:0] sum_mag;
    logic         sum_carry;
    logic [W-1:0] diff_ab;
    logic [W-1:0] diff_ba;
    logic         a_lt_b;
    sm_out_t      out_d;
    sm_out_t      out_q;

    always_comb begin
        sgn_a     = op_a[N-1];
        sgn_b_eff = op_b[N-1] ^ (sm_op_e'(op_sel) == SMOP_SUB);
        mag_a     = op_a[W-1:0];
        mag_b     = op_b[W-1:0];
    end

    sm_mag_add #(.W(W)) u_add (
        .x     (mag_a),
        .y     (mag_b),
        .sum   (sum_mag),
        .carry (sum_carry)
    );

    sm_mag_cmp #(.W(W)) u_cmp (
        .x      (mag_a),
        .y      (mag_b),
        .d_xy   (diff_ab),
        .d_yx   (diff_ba),
        .x_lt_y (a_lt_b)
    );

    always_comb begin
        out_d = '0;
        if (sgn_a == sgn_b_eff) begin
            out_d.mag  = sum_mag;
            out_d.sign = sgn_a;
            out_d.ovf  = sum_carry;
        end else if (a_lt_b) begin
            out_d.mag  = diff_ba;
            out_d.sign = sgn_b_eff;
        end else begin
            out_d.mag  = diff_ab;
            out_d.sign = sgn_a;
        end
        if (out_d.mag == '0) begin
            out_d.sign = 1'b0;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q <= '0;
                end else begin
                    out_q <= out_d;
                end
            end
        end else begin : g_comb
            always_comb begin
                out_q = out_d;
            end
        end
    endgenerate

    always_comb begin
        res = {out_q.sign, out_q.mag};
        ovf = out_q.ovf;
    end
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic         op_sel,
    input logic [N-1:0] res,
    input logic         ovf
);
    localparam int W = N - 1;

    logic [N-1:0] a_s;
    logic [N-1:0] b_s;
    logic         op_s;
    logic         armed;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    a_s   <= '0;
                    b_s   <= '0;
                    op_s  <= 1'b0;
                    armed <= 1'b0;
                end else begin
                    a_s   <= op_a;
                    b_s   <= op_b;
                    op_s  <= op_sel;
                    armed <= 1'b1;
                end
            end
        end else begin : g_now
            always_comb begin
                a_s   = op_a;
                b_s   = op_b;
                op_s  = op_sel;
                armed = 1'b1;
            end
        end
    endgenerate

    logic         sa;
    logic         sb;
    logic [W-1:0] ma;
    logic [W-1:0] mb;
    logic [W-1:0] ab_diff;
    logic [W-1:0] ba_diff;

    always_comb begin
        sa      = a_s[N-1];
        sb      = b_s[N-1] ^ op_s;
        ma      = a_s[W-1:0];
        mb      = b_s[W-1:0];
        ab_diff = ma - mb;
        ba_diff = mb - ma;
    end

    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (res[W-1:0] == '0) |-> !res[N-1]); // R7

    AST_OVF_SAME_SIGN: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ovf |-> (sa == sb)); // R8

    AST_SAME_SIGN_FOLLOWS_A: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((sa == sb) && (res[W-1:0] != '0)) |-> (res[N-1] == sa)); // R3

    AST_DIFF_A_LARGER: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((sa != sb) && (ma > mb)) |-> (res == {sa, ab_diff})); // R4

    AST_DIFF_B_LARGER: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((sa != sb) && (ma < mb)) |-> (res == {sb, ba_diff})); // R5

    AST_EQUAL_CANCEL: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((sa != sb) && (ma == mb)) |-> ((res == '0) && !ovf)); // R6
endmodule

bind sm_addsub sm_addsub_chk #(.N(N), .REG_OUT(REG_OUT)) u_sm_addsub_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_a   (op_a),
    .op_b   (op_b),
    .op_sel (op_sel),
    .res    (res),
    .ovf    (ovf)
);

// File: tb/sm_addsub_bench.sv
module sm_addsub_bench;
    localparam int N = 5;
    localparam int W = N - 1;
    localparam int MAXM = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic         op_sel = 1'b0;
    logic [N-1:0] res;
    logic         ovf;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    sm_addsub #(.N(N), .REG_OUT(1'b1)) u_sm_addsub (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_a   (op_a),
        .op_b   (op_b),
        .op_sel (op_sel),
        .res    (res),
        .ovf    (ovf)
    );

    task automatic check(input string tag, input logic [N-1:0] exp_res, input logic exp_ovf);
        n_checks++;
        if (res !== exp_res || ovf !== exp_ovf) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h op=%0d got res=%h ovf=%0d exp res=%h ovf=%0d",
                     tag, op_a, op_b, op_sel, res, ovf, exp_res, exp_ovf);
        end
    endtask

    function automatic int sm_val(input logic [N-1:0] x);
        return x[N-1] ? -int'(x[W-1:0]) : int'(x[W-1:0]);
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog: got cycles=%0d exp below 100000", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        // R9: outputs held at zero while reset is low, even with busy inputs
        op_a = 5'b0_0111;
        op_b = 5'b0_0011;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset", '0, 1'b0);
        rst_n = 1'b1;

        for (int op = 0; op < 2; op++) begin
            for (int a = 0; a < (1 << N); a++) begin
                for (int b = 0; b < (1 << N); b++) begin
                    logic [N-1:0] exp_r;
                    logic         exp_o;
                    logic         sa;
                    logic         sb;
                    int           ma;
                    int           mb;
                    int           r;
                    int           mabs;
                    string        tag;
                    @(negedge clk);
                    op_a   = N'(a);
                    op_b   = N'(b);
                    op_sel = op[0];
                    sa = op_a[N-1];
                    sb = op_b[N-1] ^ op_sel;
                    ma = int'(op_a[W-1:0]);
                    mb = int'(op_b[W-1:0]);
                    r  = (op == 1) ? sm_val(op_a) - sm_val(op_b) : sm_val(op_a) + sm_val(op_b);
                    mabs = (r < 0) ? -r : r;
                    if (mabs > MAXM) begin
                        exp_o = 1'b1;
                        exp_r[W-1:0] = W'(mabs);
                        exp_r[N-1]   = (exp_r[W-1:0] == '0) ? 1'b0 : (r < 0);
                    end else begin
                        exp_o = 1'b0;
                        exp_r[W-1:0] = W'(mabs);
                        exp_r[N-1]   = (r < 0);
                    end
                    if (sa == sb) begin
                        if (exp_o)                      tag = "R8";
                        else if (ma == 0 && mb == 0)    tag = "R7";
                        else                            tag = "R3";
                    end else if (ma > mb) begin
                        tag = "R4";
                    end else if (ma < mb) begin
                        tag = "R5";
                    end else begin
                        tag = "R6";
                    end
                    // R1 covers add, R2 covers subtract
                    tag = {tag, (op == 1) ? " R2" : " R1"};
                    @(negedge clk);
                    check({tag, " R9 latency"}, exp_r, exp_o);
                end
            end
        end

        // R9: reset clears a non-zero overflowing result
        @(negedge clk);
        op_a   = 5'b1_1000;
        op_b   = 5'b1_1000;
        op_sel = 1'b0;
        @(negedge clk);
        check("R8 R7 neg wrap", '0, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R9 async clear", '0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule